// File: doc/BRIEF.md
# Indexed Register Access Port

This block gives a host a two-location window into a bank of up to 128 internal byte registers. One location holds a register pointer. The other moves a byte to or from whichever register the pointer selects. Every data write advances the pointer by one, so the host loads a run of consecutive registers by setting the pointer once and then streaming bytes into the data location.

On the host side there is an active-low chip-select, one address bit, read and write strobes and byte-wide data buses. On the register side the block presents a single-cycle write strobe together with the register index and byte, and it takes back the byte that the bank returns for the current pointer. The host interface has no back-pressure: a write completes in the cycle its strobe is first seen, and read data is valid in the same cycle as the read strobe. A host bus write cycle is the run of consecutive clock cycles in which chip-select and the write strobe are both active. Holding the write strobe for several clocks still counts as one access. The meaning of the registers in the bank is outside this block.

Top module: `regwin_port`

## Requirements
- R1: While cs_n_i is high, no access takes place: reg_we_o stays low, the pointer keeps its value and rdata_o reads 00h.
- R2: A write with addr_i = 0 loads wdata_i[6:0] into the pointer, and bit 7 is ignored.
- R3: A read with addr_i = 0 and wr_en_i low returns the pointer on rdata_o[6:0], with rdata_o[7] = 0.
- R4: A write with addr_i = 1 drives reg_we_o high for exactly one cycle, starting the cycle after the write is first seen. During that cycle reg_addr_o holds the pointer value from before the write and reg_wdata_o holds the written byte.
- R5: Each data write (addr_i = 1) advances the pointer by one, and 7Fh advances to 00h.
- R6: A read with addr_i = 1 and wr_en_i low returns reg_rdata_i for the current pointer on rdata_o, and leaves the pointer unchanged.
- R7: After reset the pointer is 00h and reg_we_o is low.
- R8: A write cycle held for any number of clocks produces one register strobe and advances the pointer once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low window select |
| addr_i | input | 1 | 0 selects the pointer, 1 selects the data location |
| rd_en_i | input | 1 | Host read strobe |
| wr_en_i | input | 1 | Host write strobe; a write cycle is every clock in which it is held high |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte; 00h when no read is selected |
| reg_we_o | output | 1 | Single-cycle write strobe to the register bank |
| reg_addr_o | output | 7 | Register index: the captured write index while reg_we_o is high, the current pointer otherwise |
| reg_wdata_o | output | 8 | Byte to write into the register bank |
| reg_rdata_i | input | 8 | Byte the bank returns for reg_addr_o |

## Verification
The pointer is written with all 256 byte values and read back each time. This separates correct masking of bit 7 from a pointer that stores or returns it. A full 128-byte burst from index 0 is then read back register by register. A misplaced strobe index, a data write that leaves the pointer alone, or a missing wrap from 7Fh to 00h shows up as a wrong byte or a wrong final pointer. Short bursts across the wrap point, with write strobes held for one to three clocks, tell one strobe per bus cycle apart from one per clock. Accesses made while the window is deselected show whether chip-select really gates the strobe, the pointer and the read bus.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  // Decoded host access for one clock cycle.
  typedef struct packed {
    logic ptr_load;   // first clock of a pointer write
    logic data_wr;    // first clock of a data write
    logic ptr_rd;     // pointer read in progress
    logic data_rd;    // data read in progress
  } regwin_acc_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_i,
  input  logic        addr_i,
  input  logic        rd_en_i,
  input  logic        wr_en_i,
  output regwin_acc_t acc_o
);
  logic wr_act;
  logic wr_act_q;
  logic wr_first;
  logic rd_act;

  assign wr_act   = !cs_n_i && wr_en_i;
  assign rd_act   = !cs_n_i && rd_en_i && !wr_en_i;
  assign wr_first = wr_act && !wr_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_act_q <= 1'b0;
    else        wr_act_q <= wr_act;
  end

  always_comb begin
    acc_o.ptr_load = wr_first && !addr_i;
    acc_o.data_wr  = wr_first && addr_i;
    acc_o.ptr_rd   = rd_act && !addr_i;
    acc_o.data_rd  = rd_act && addr_i;
  end

  // R8
  held_write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && $past(wr_act)) |-> !(acc_o.ptr_load || acc_o.data_wr));
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             hold_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (step_i) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R5
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));

  // R6
  ptr_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !load_i && !step_i) |=> $stable(ptr_q));
endmodule

// File: rtl/regwin_wrstage.sv
module regwin_wrstage #(
  parameter int PTR_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [PTR_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [PTR_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  logic              we_q;
  logic [PTR_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      we_q <= fire_i;
      if (fire_i) begin
        idx_q  <= idx_i;
        data_q <= data_i;
      end
    end
  end

  assign we_o   = we_q;
  assign idx_o  = idx_q;
  assign data_o = data_q;

  // R4
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
endmodule

// File: rtl/regwin_port.sv
module regwin_port
  import regwin_pkg::*;
#(
  parameter int PTR_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reg_we_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int PAD_W = DATA_W - PTR_W;

  regwin_acc_t       acc;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  wr_idx;
  logic              we;

  regwin_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_i  (cs_n_i),
    .addr_i  (addr_i),
    .rd_en_i (rd_en_i),
    .wr_en_i (wr_en_i),
    .acc_o   (acc)
  );

  regwin_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (acc.ptr_load),
    .load_val_i (wdata_i[PTR_W-1:0]),
    .step_i     (acc.data_wr),
    .hold_i     (acc.data_rd),
    .ptr_o      (ptr)
  );

  regwin_wrstage #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_wrstage (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (acc.data_wr),
    .idx_i  (ptr),
    .data_i (wdata_i),
    .we_o   (we),
    .idx_o  (wr_idx),
    .data_o (reg_wdata_o)
  );

  assign reg_we_o   = we;
  assign reg_addr_o = we ? wr_idx : ptr;

  always_comb begin
    if (acc.ptr_rd)       rdata_o = {{PAD_W{1'b0}}, ptr};
    else if (acc.data_rd) rdata_o = reg_rdata_i;
    else                  rdata_o = '0;
  end

  initial begin
    if (DATA_W <= PTR_W) $error("regwin_port: DATA_W must exceed PTR_W");
  end

  // R1
  desel_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> !reg_we_o);

  // R1
  desel_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |-> rdata_o == '0);

  // R3
  ptr_read_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && rd_en_i && !wr_en_i && !addr_i) |-> rdata_o[DATA_W-1:PTR_W] == '0);
endmodule

// File: tb/regwin_port_tb_top.sv
module regwin_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       addr = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  logic [7:0] bank [128];
  int checks = 0;
  int errors = 0;
  int strobes = 0;

  always #5 clk = ~clk;

  regwin_port dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n),
    .addr_i      (addr),
    .rd_en_i     (rd_en),
    .wr_en_i     (wr_en),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .reg_we_o    (reg_we),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (reg_rdata)
  );

  // Register bank model driven by the register side of the port.
  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) begin
    if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      strobes = strobes + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic a, input logic [7:0] d, input int hold);
    @(negedge clk);
    cs_n = 1'b0; addr = a; wdata = d; wr_en = 1'b1;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1; wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic hread(input logic a, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_en = 1'b1;
    #2 v = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0;
    for (int i = 0; i < 128; i++) bank[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    check("R7 strobe after reset", int'(reg_we), 0);
    hread(1'b0, v);
    check("R7 pointer after reset", int'(v), 0);

    // R2 / R3 pointer load and readback over every byte value
    for (int p = 0; p < 256; p++) begin
      hwrite(1'b0, 8'(p), 1);
      hread(1'b0, v);
      check("R2 R3 pointer readback", int'(v), p & 8'h7F);
    end

    // R4 R5 R8 short bursts across the wrap with varying hold lengths
    hwrite(1'b0, 8'h7C, 2);
    for (int i = 0; i < 8; i++) begin
      s0 = strobes;
      hwrite(1'b1, 8'((i * 37 + 3) & 8'hFF), (i % 3) + 1);
      check("R8 one strobe per write cycle", strobes - s0, 1);
      hread(1'b0, v);
      check("R5 pointer advance with wrap", int'(v), (8'h7C + i + 1) & 8'h7F);
    end
    for (int i = 0; i < 8; i++) begin
      check("R4 burst byte landed at pointer index",
            int'(bank[(8'h7C + i) & 8'h7F]), (i * 37 + 3) & 8'hFF);
    end

    // R4 R5 full 128-byte burst from index 0
    hwrite(1'b0, 8'h00, 1);
    for (int i = 0; i < 128; i++) hwrite(1'b1, 8'((i * 13 + 7) & 8'hFF), 1);
    hread(1'b0, v);
    check("R5 pointer wrapped to 00h", int'(v), 0);

    // R6 data reads return the bank and keep the pointer
    for (int i = 0; i < 128; i++) begin
      hwrite(1'b0, 8'(i), 1);
      hread(1'b1, v);
      check("R4 R6 data readback", int'(v), (i * 13 + 7) & 8'hFF);
      hread(1'b1, v);
      check("R6 repeated data read", int'(v), (i * 13 + 7) & 8'hFF);
      hread(1'b0, v);
      check("R6 pointer unchanged by read", int'(v), i);
    end

    // R1 deselected window
    hwrite(1'b0, 8'h15, 1);
    s0 = strobes;
    @(negedge clk);
    cs_n = 1'b1; addr = 1'b1; wdata = 8'hA5; wr_en = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; wdata = 8'h40;
    wr_en = 1'b1;
    repeat (2) @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = 1'b1;
    #2 check("R1 read bus quiet when deselected", int'(rdata), 0);
    @(negedge clk);
    rd_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 no strobe when deselected", strobes - s0, 0);
    hread(1'b0, v);
    check("R1 pointer unchanged when deselected", int'(v), 8'h15);
    check("R1 bank byte untouched", int'(bank[8'h15]), (8'h15 * 13 + 7) & 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule